// File: doc/BRIEF.md
# Windowed Watchdog Reset Supervisor

This block sequences a system reset from a digital supply-valid flag and a synchronous copy of a voltage-monitor comparator. It holds reset low through power-up, then for a fixed power-on delay once both conditions are met. It pulls reset low again at once if the monitored voltage sags. Every duration is counted in ticks of a prescaled timebase input. The power-on delay, the two watchdog windows and the reset pulse are all whole multiples of one base unit of `UNIT_TICKS` ticks. The power-on delay is 40 units, the closed window 32 units, the open window 16 units and the watchdog reset pulse 1 unit.

Once reset is released, a windowed watchdog runs. A rising edge on the service input is only valid inside the open window. An edge during the closed window, or no edge before the open window ends, produces one fixed-width reset pulse, after which a fresh closed window begins. The reset output is a pull-down enable for an open-drain pin. The active-low enable output turns on only after the first valid service that follows any reset.

Top module: `wds_supervisor`

## Requirements
- R1: While `rst_n` is low, or while the synchronised supply flag or comparator is low, `rst_pull` is 1 and `en_n` is 1.
- R2: When both supply flag and comparator become high, `rst_pull` is released exactly `SYNC_STAGES + 1 + 40*UNIT_TICKS` clock edges after the inputs change, counting the first edge that samples them and with `tick` high on every cycle.
- R3: The comparator going low forces `rst_pull` to 1 within `SYNC_STAGES + 1` clock edges, whatever the watchdog state.
- R4: A comparator dip during the power-on delay, followed by recovery, restarts the full power-on delay from its beginning.
- R5: The closed window lasts `32*UNIT_TICKS` ticks after reset release or a service. A rising edge of `wd_clear` seen while it is active starts a reset pulse.
- R6: A rising edge of `wd_clear` seen in the open window (`16*UNIT_TICKS` ticks, following the closed window) is a valid service. It starts a new closed window and drives `en_n` to 0. An edge seen on the last open-window tick still counts as a service.
- R7: If no rising edge is seen before the open window expires, a reset pulse starts on the expiry edge.
- R8: A watchdog reset pulse lasts exactly `UNIT_TICKS` ticks and is followed by a closed window with `en_n` still 1.
- R9: `en_n` is 1 whenever `rst_pull` is 1, and stays 1 after reset release until the next valid service.
- R10: A `wd_clear` held at a constant level has no effect, and `wd_clear` edges during power-on delay or a reset pulse are ignored.
- R11: Timers advance only on cycles with `tick` high. With `tick` low, the current window does not elapse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset of the logic |
| tick | input | 1 | One-cycle timebase strobe; all durations count these |
| supply_ok | input | 1 | Asynchronous supply-valid flag, high when the supply is usable |
| vmon_above | input | 1 | Asynchronous comparator result, high when the monitored voltage exceeds its reference |
| wd_clear | input | 1 | Asynchronous watchdog service input; rising edges count |
| rst_pull | output | 1 | 1 turns on the pull-down of the open-drain active-low reset pin |
| en_n | output | 1 | Active-low enable, push-pull |

## Verification
The bench builds the block with `UNIT_TICKS = 2` and `SYNC_STAGES = 2`. This makes the power-on delay 80 ticks, the windows 64 and 32 ticks and the reset pulse 2 ticks, so every window edge is reached in a few hundred cycles. With a two-tick pulse, the first and last pulse cycles can be told apart, which exposes an off-by-one in pulse width. The small windows also let the bench place a service edge on the last closed-window cycle, the first open-window cycle and the last open-window cycle. Holding `tick` low for longer than a whole window shows that time is counted in ticks and not in clocks.

// File: rtl/wds_pkg.sv
package wds_pkg;
   typedef enum logic [2:0] {
      ST_HOLD   = 3'd0,
      ST_POR    = 3'd1,
      ST_CLOSED = 3'd2,
      ST_OPEN   = 3'd3,
      ST_PULSE  = 3'd4
   } wds_state_e;

   function automatic logic in_reset(input wds_state_e s);
      return (s == ST_HOLD) || (s == ST_POR) || (s == ST_PULSE);
   endfunction
endpackage

// File: rtl/wds_sync.sv
module wds_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("wds_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("wds_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= '0;
            else        stage_q[i] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= '0;
            else        stage_q[i] <= stage_q[i-1];
         end
      end
   end

   assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/wds_tick_timer.sv
module wds_tick_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             tick,
   input  logic [CNT_W-1:0] limit,
   output logic             expire
);
   if (CNT_W < 1) begin : g_bad_w
      $error("wds_tick_timer: CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   assign expire = tick && (cnt_q == (limit - 1'b1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (restart || expire) cnt_q <= '0;
      else if (tick)              cnt_q <= cnt_q + 1'b1;
   end

   // R8: the count never reaches the limit of the running interval
   assert_cnt_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < limit)
      else $error("tick timer count out of range");
endmodule

// File: rtl/wds_supervisor.sv
module wds_supervisor #(
   parameter int UNIT_TICKS  = 2500,
   parameter int POR_UNITS   = 40,
   parameter int CLOSE_UNITS = 32,
   parameter int OPEN_UNITS  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic supply_ok,
   input  logic vmon_above,
   input  logic wd_clear,
   output logic rst_pull,
   output logic en_n
);
   import wds_pkg::*;

   localparam int POR_TICKS   = POR_UNITS * UNIT_TICKS;
   localparam int CLOSE_TICKS = CLOSE_UNITS * UNIT_TICKS;
   localparam int OPEN_TICKS  = OPEN_UNITS * UNIT_TICKS;
   localparam int PULSE_TICKS = UNIT_TICKS;
   localparam int MAX_A       = (POR_TICKS > CLOSE_TICKS) ? POR_TICKS : CLOSE_TICKS;
   localparam int MAX_TICKS   = (MAX_A > OPEN_TICKS) ? MAX_A : OPEN_TICKS;
   localparam int CNT_W       = $clog2(MAX_TICKS + 1);

   if (UNIT_TICKS < 1 || POR_UNITS < 1 || CLOSE_UNITS < 1 || OPEN_UNITS < 1) begin : g_bad_dur
      $error("wds_supervisor: every duration must be at least one tick");
   end

   logic [2:0] raw_in, sync_out;
   logic       sup_s, vmon_s, clr_s, clr_prev_q, clr_rise, pwr_good;
   wds_state_e state_q, state_d;
   logic       en_n_q, en_n_d;
   logic       restart, expire;
   logic [CNT_W-1:0] limit;

   assign raw_in = {wd_clear, vmon_above, supply_ok};

   wds_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_async(raw_in),
      .q_sync (sync_out)
   );

   assign sup_s    = sync_out[0];
   assign vmon_s   = sync_out[1];
   assign clr_s    = sync_out[2];
   assign pwr_good = sup_s & vmon_s;
   assign clr_rise = clr_s & ~clr_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clr_prev_q <= 1'b0;
      else        clr_prev_q <= clr_s;
   end

   always_comb begin
      case (state_q)
         ST_POR:    limit = CNT_W'(POR_TICKS);
         ST_CLOSED: limit = CNT_W'(CLOSE_TICKS);
         ST_OPEN:   limit = CNT_W'(OPEN_TICKS);
         ST_PULSE:  limit = CNT_W'(PULSE_TICKS);
         default:   limit = CNT_W'(1);
      endcase
   end

   wds_tick_timer #(.CNT_W(CNT_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(restart),
      .tick   (tick),
      .limit  (limit),
      .expire (expire)
   );

   always_comb begin
      state_d = state_q;
      en_n_d  = en_n_q;
      if (!pwr_good) begin
         state_d = ST_HOLD;
      end else begin
         case (state_q)
            ST_HOLD:   state_d = ST_POR;
            ST_POR:    if (expire) state_d = ST_CLOSED;
            ST_CLOSED: begin
               if (clr_rise)    state_d = ST_PULSE;
               else if (expire) state_d = ST_OPEN;
            end
            ST_OPEN: begin
               if (clr_rise) begin
                  state_d = ST_CLOSED;
                  en_n_d  = 1'b0;
               end else if (expire) begin
                  state_d = ST_PULSE;
               end
            end
            ST_PULSE:  if (expire) state_d = ST_CLOSED;
            default:   state_d = ST_HOLD;
         endcase
      end
      if (in_reset(state_d)) en_n_d = 1'b1;
   end

   assign restart = (state_d != state_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_HOLD;
         en_n_q  <= 1'b1;
      end else begin
         state_q <= state_d;
         en_n_q  <= en_n_d;
      end
   end

   assign rst_pull = in_reset(state_q);
   assign en_n     = en_n_q;

   // R3: a failed power condition drives reset on the next edge
   assert_pd_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good |=> rst_pull)
      else $error("power-down did not assert reset");

   // R9: enable never active while reset is pulled
   assert_en_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pull |-> en_n)
      else $error("enable active during reset");

   // R5: early service leads to a reset pulse
   assert_early_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_good && state_q == ST_CLOSED && clr_rise) |=> (state_q == ST_PULSE && rst_pull))
      else $error("closed-window clear did not pulse reset");

   // R6: in-window service restarts the closed window and enables
   assert_service_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_good && state_q == ST_OPEN && clr_rise) |=> (state_q == ST_CLOSED && !en_n))
      else $error("valid service not taken");

   // R11: without a tick or an edge, a running interval holds its state
   assert_no_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && pwr_good && state_q != ST_HOLD && !clr_rise) |=> $stable(state_q))
      else $error("state advanced without a tick");
endmodule

// File: tb/wds_supervisor_tb.sv
module wds_supervisor_tb;
   localparam int UNIT = 2;
   localparam int SYNC = 2;
   localparam int POR  = 40 * UNIT;
   localparam int CW   = 32 * UNIT;
   localparam int OW   = 16 * UNIT;

   typedef struct packed {
      logic       sup;
      logic       cmp;
      logic       clr;
      logic [7:0] wait_c;
      logic       exp_rst;
      logic       exp_en_n;
      logic [3:0] req;
   } vec_t;

   // Timeline in edges after reset release (t=0); inputs change, then wait_c edges.
   localparam vec_t VECS [13] = '{
      '{1'b1, 1'b1, 1'b0, 8'd20, 1'b0, 1'b1, 4'd5},  // R5 t=20 closed, quiet
      '{1'b1, 1'b1, 1'b0, 8'd50, 1'b0, 1'b1, 4'd5},  // R5 t=70 open window
      '{1'b1, 1'b1, 1'b1, 8'd10, 1'b0, 1'b0, 4'd6},  // R6 service at edge 73
      '{1'b1, 1'b1, 1'b0, 8'd10, 1'b0, 1'b0, 4'd6},  // R6 t=90 new closed window
      '{1'b1, 1'b1, 1'b1, 8'd4,  1'b1, 1'b1, 4'd5},  // R5 early edge -> pulse
      '{1'b1, 1'b1, 1'b1, 8'd4,  1'b0, 1'b1, 4'd8},  // R8 pulse over, held level
      '{1'b1, 1'b1, 1'b0, 8'd4,  1'b0, 1'b1, 4'd10}, // R10 level hold had no effect
      '{1'b1, 1'b1, 1'b0, 8'd90, 1'b1, 1'b1, 4'd7},  // R7 open expired at 191
      '{1'b1, 1'b1, 1'b0, 8'd4,  1'b0, 1'b1, 4'd8},  // R8 closed again
      '{1'b1, 1'b0, 1'b0, 8'd4,  1'b1, 1'b1, 4'd3},  // R3 comparator drop
      '{1'b1, 1'b1, 1'b0, 8'd40, 1'b1, 1'b1, 4'd4},  // R4 recovering, in delay
      '{1'b1, 1'b1, 1'b0, 8'd50, 1'b0, 1'b1, 4'd4},  // R4 released after delay
      '{1'b0, 1'b1, 1'b0, 8'd5,  1'b1, 1'b1, 4'd1}   // R1 supply flag lost
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b1;
   logic supply_ok = 1'b0;
   logic vmon_above = 1'b0;
   logic wd_clear = 1'b0;
   logic rst_pull, en_n;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   wds_supervisor #(.UNIT_TICKS(UNIT), .SYNC_STAGES(SYNC)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .supply_ok (supply_ok),
      .vmon_above(vmon_above),
      .wd_clear  (wd_clear),
      .rst_pull  (rst_pull),
      .en_n      (en_n)
   );

   task automatic check(input string tag, input logic got, input logic exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic power_up(input bit wiggle, output int n);
      rst_n = 1'b0; supply_ok = 1'b0; vmon_above = 1'b0; wd_clear = 1'b0; tick = 1'b1;
      step(3);
      check("R1 in reset rst_pull", rst_pull, 1'b1);
      check("R1 in reset en_n", en_n, 1'b1);
      rst_n = 1'b1;
      step(2);
      check("R1 inputs low rst_pull", rst_pull, 1'b1);
      supply_ok = 1'b1; vmon_above = 1'b1;
      n = 0;
      do begin
         if (wiggle) wd_clear = ~wd_clear;
         step(1);
         n++;
      end while (rst_pull && n < 1000);
      wd_clear = 1'b0;
   endtask

   initial begin
      int n;
      @(negedge clk);

      // R2: exact power-on delay
      power_up(1'b0, n);
      n_checks++;
      if (n != POR + SYNC + 1) begin
         n_fail++;
         $display("FAIL R2 power-on edges: got %0d expected %0d", n, POR + SYNC + 1);
      end
      check("R9 enable off after release", en_n, 1'b1);

      // Vector table from t=0
      foreach (VECS[i]) begin
         supply_ok = VECS[i].sup; vmon_above = VECS[i].cmp; wd_clear = VECS[i].clr;
         step(int'(VECS[i].wait_c));
         n_checks += 2;
         if (rst_pull !== VECS[i].exp_rst || en_n !== VECS[i].exp_en_n) begin
            n_fail++;
            $display("FAIL R%0d vector %0d: got rst=%b en_n=%b expected rst=%b en_n=%b",
                     VECS[i].req, i, rst_pull, en_n, VECS[i].exp_rst, VECS[i].exp_en_n);
         end
      end

      // R10: service edges during the power-on delay are ignored
      power_up(1'b1, n);
      n_checks++;
      if (n != POR + SYNC + 1) begin
         n_fail++;
         $display("FAIL R10 power-on edges with clear toggling: got %0d expected %0d", n, POR + SYNC + 1);
      end
      check("R10 enable stays off", en_n, 1'b1);

      // R5: edge seen on the last closed-window edge
      power_up(1'b0, n);
      step(CW - 3); wd_clear = 1'b1; step(3);
      check("R5 last closed edge pulses", rst_pull, 1'b1);

      // R6: edge seen on the first open-window edge
      power_up(1'b0, n);
      step(CW - 2); wd_clear = 1'b1; step(3);
      check("R6 first open edge rst_pull", rst_pull, 1'b0);
      check("R6 first open edge en_n", en_n, 1'b0);

      // R6: edge on the open expiry edge still services
      power_up(1'b0, n);
      step(CW + OW - 3); wd_clear = 1'b1; step(3);
      check("R6 expiry-edge service rst_pull", rst_pull, 1'b0);
      check("R6 expiry-edge service en_n", en_n, 1'b0);

      // R7 / R8: exact expiry and pulse width
      power_up(1'b0, n);
      step(CW + OW - 1);
      check("R7 before expiry", rst_pull, 1'b0);
      step(1);
      check("R7 pulse starts on expiry", rst_pull, 1'b1);
      step(UNIT - 1);
      check("R8 last pulse cycle", rst_pull, 1'b1);
      step(1);
      check("R8 pulse ended", rst_pull, 1'b0);
      check("R8 enable still off", en_n, 1'b1);

      // R11: no ticks, window does not elapse
      power_up(1'b0, n);
      tick = 1'b0;
      step(CW + OW + 20);
      check("R11 no pulse without ticks", rst_pull, 1'b0);
      wd_clear = 1'b1; step(3);
      check("R11 still in closed window", rst_pull, 1'b1);
      tick = 1'b1; wd_clear = 1'b0;

      // R4: dip during the delay restarts it in full
      rst_n = 1'b0; supply_ok = 1'b0; vmon_above = 1'b0; step(2);
      rst_n = 1'b1; step(1);
      supply_ok = 1'b1; vmon_above = 1'b1; step(50);
      vmon_above = 1'b0; step(SYNC + 1);
      check("R3 dip asserts reset", rst_pull, 1'b1);
      vmon_above = 1'b1;
      n = 0;
      do begin step(1); n++; end while (rst_pull && n < 1000);
      n_checks++;
      if (n != POR + SYNC + 1) begin
         n_fail++;
         $display("FAIL R4 restarted delay edges: got %0d expected %0d", n, POR + SYNC + 1);
      end

      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule